// File: doc/BRIEF.md
# Radix-10 Restoring Shift-Subtract Divider

A sequential fixed-point divider for decimal significands coded as BCD-8421. Both operands are normalized p-digit fractions (leading digit non-zero). A one-cycle start strobe captures them. The block then produces the unsigned quotient one decimal digit per clock, until it holds p significant digits plus one rounding digit. It ends the operation with a one-cycle done pulse.

Before the first digit is computed, the block builds the nine divisor multiples 1x to 9x and keeps them in registers:

- 2x comes from recoding every digit to BCD-5421 and shifting the word left by one bit.
- 5x comes from shifting the BCD-8421 word left by three bits and recoding the result from BCD-5421.
- The other multiples each take a single decimal adder or subtractor, working on 1x, 2x, 5x and 10x.

In each iteration, nine full-width decimal subtractors take every multiple away from the shifted residual at once. The largest index that leaves a non-negative difference becomes the digit, and that difference becomes the new residual.

Quotient-plus-one is built alongside the quotient, so that a later rounding stage needs no decimal incrementer. A leading zero quotient digit (dividend smaller than divisor) is dropped and one extra digit is computed in its place. A sticky flag reports a non-zero final remainder. Exponents, special values and rounding belong to surrounding logic.

Top module: `dec_restoring_div`

## Requirements
- R1: While reset is active, quotient, quotient_plus1, sticky and done are all zero.
- R2: When dividend X >= divisor D (both p-digit integers with non-zero top digit), the quotient at done equals floor(X*10^p/D) as p+1 BCD digits, 4 bits each, most significant digit in the top nibble.
- R3: When X < D, the leading zero digit is discarded and the quotient equals floor(X*10^(p+1)/D) as p+1 BCD digits; its top nibble is never zero.
- R4: At done, quotient_plus1 equals the quotient value plus one, coded as p+2 BCD digits (one more digit than the quotient, so that an all-nines quotient carries out).
- R5: At done, sticky is 1 exactly when the remainder N - Q*D is non-zero, where N is the scaled dividend of R2 or R3 and Q the reported quotient.
- R6: done is high in the cycle after the (p+3)-th rising edge that follows the edge accepting start, or after the (p+4)-th when X < D.
- R7: done is high for exactly one cycle per accepted division.
- R8: A start while a division is in progress (from the accepting edge through the cycle before done) is ignored: its operands are not used and no extra done appears.
- R9: A start presented in the same cycle that done is high is accepted and begins a new division.
- R10: Results are exact for divisors containing digits 5 to 9, which exercise the doubled and quintupled multiples built by digit recoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; taken only when idle or in the done cycle |
| dividend | input | 4*DIGITS | Normalized dividend, BCD-8421, most significant digit on top |
| divisor | input | 4*DIGITS | Normalized divisor, BCD-8421, most significant digit on top |
| quotient | output | 4*(DIGITS+1) | Normalized quotient digits including rounding digit, BCD-8421 |
| quotient_plus1 | output | 4*(DIGITS+2) | Quotient plus one unit in the last place, BCD-8421 |
| sticky | output | 1 | Final remainder non-zero |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
Two functions can land in the same cycle. One is the completion of a division, where done pulses and the result is presented. The other is the acceptance of the next start, which the block allows in exactly that cycle. The bench provokes this by raising start at the very cycle it sees done. It judges the overlap by comparing both the finished result and the following result against values computed independently, including the second operation's latency counted from its accepting edge. The bench also presents a start with different operands while a division is running, and expects that division's result to stay unaffected and no extra done pulse to appear.

// File: rtl/dd_div_pkg.sv
package dd_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ITER = 2'd2,
        ST_FIN  = 2'd3
    } dd_state_e;

    // BCD-8421 digit to BCD-5421 code (values 5..9 move up by three)
    function automatic logic [3:0] to_5421(input logic [3:0] d);
        return (d >= 4'd5) ? d + 4'd3 : d;
    endfunction

    // BCD-5421 code back to BCD-8421 digit
    function automatic logic [3:0] from_5421(input logic [3:0] c);
        return c[3] ? ({1'b0, c[2:0]} + 4'd5) : c;
    endfunction

endpackage

// File: rtl/dd_bcd_addsub.sv
module dd_bcd_addsub #(
    parameter int NDIG = 17
) (
    input  logic [NDIG*4-1:0] a,
    input  logic [NDIG*4-1:0] b,
    input  logic              sub,
    output logic [NDIG*4-1:0] y,
    output logic              cout
);
    // Ripple decimal adder / subtractor; cout is carry (add) or borrow (sub)
    always_comb begin
        logic [4:0] t;
        logic       c;
        c = 1'b0;
        y = '0;
        for (int i = 0; i < NDIG; i++) begin
            if (sub) begin
                t = {1'b0, a[i*4 +: 4]} - {1'b0, b[i*4 +: 4]} - {4'b0, c};
                if (t[4]) begin
                    t = t + 5'd10;
                    c = 1'b1;
                end else begin
                    c = 1'b0;
                end
            end else begin
                t = {1'b0, a[i*4 +: 4]} + {1'b0, b[i*4 +: 4]} + {4'b0, c};
                if (t > 5'd9) begin
                    t = t - 5'd10;
                    c = 1'b1;
                end else begin
                    c = 1'b0;
                end
            end
            y[i*4 +: 4] = t[3:0];
        end
        cout = c;
    end
endmodule

// File: rtl/dd_multiples.sv
module dd_multiples
    import dd_div_pkg::*;
#(
    parameter int DIGITS = 16
) (
    input  logic [DIGITS*4-1:0]             divisor,
    output logic [9:1][(DIGITS+1)*4-1:0]    mult
);
    localparam int MD   = DIGITS + 1;
    localparam int MW   = MD * 4;
    localparam int NADD = 6;

    logic [MW-1:0] m1, m2, m5, m10, rec, sh;

    always_comb begin
        m1  = {4'h0, divisor};
        m10 = {divisor, 4'h0};
        // doubling: 5421 recode, then one-bit left shift of the whole word
        for (int i = 0; i < MD; i++) rec[i*4 +: 4] = to_5421(m1[i*4 +: 4]);
        m2 = rec << 1;
        // quintupling: three-bit left shift read as 5421, recoded back
        sh = m1 << 3;
        for (int i = 0; i < MD; i++) m5[i*4 +: 4] = from_5421(sh[i*4 +: 4]);
    end

    logic [NADD-1:0][MW-1:0] add_a, add_b, add_y;
    logic [NADD-1:0]         add_sub, carry_unused;

    always_comb begin
        add_a[0] = m2;  add_b[0] = m1; add_sub[0] = 1'b0;   // 3x
        add_a[1] = m2;  add_b[1] = m2; add_sub[1] = 1'b0;   // 4x
        add_a[2] = m5;  add_b[2] = m1; add_sub[2] = 1'b0;   // 6x
        add_a[3] = m5;  add_b[3] = m2; add_sub[3] = 1'b0;   // 7x
        add_a[4] = m10; add_b[4] = m2; add_sub[4] = 1'b1;   // 8x
        add_a[5] = m10; add_b[5] = m1; add_sub[5] = 1'b1;   // 9x
    end

    generate
        for (genvar k = 0; k < NADD; k++) begin : g_add
            dd_bcd_addsub #(.NDIG(MD)) u_addsub (
                .a    (add_a[k]),
                .b    (add_b[k]),
                .sub  (add_sub[k]),
                .y    (add_y[k]),
                .cout (carry_unused[k])
            );
        end
    endgenerate

    always_comb begin
        mult[1] = m1;
        mult[2] = m2;
        mult[3] = add_y[0];
        mult[4] = add_y[1];
        mult[5] = m5;
        mult[6] = add_y[2];
        mult[7] = add_y[3];
        mult[8] = add_y[4];
        mult[9] = add_y[5];
    end
endmodule

// File: rtl/dd_digit_sel.sv
module dd_digit_sel #(
    parameter int DIGITS = 16
) (
    input  logic [(DIGITS+1)*4-1:0]          w,
    input  logic [9:1][(DIGITS+1)*4-1:0]     mult,
    output logic [3:0]                       qdig,
    output logic [(DIGITS+1)*4-1:0]          rem
);
    localparam int MD = DIGITS + 1;
    localparam int MW = MD * 4;

    logic [9:1][MW-1:0] diff;
    logic [9:1]         borrow;

    generate
        for (genvar k = 1; k <= 9; k++) begin : g_sub
            dd_bcd_addsub #(.NDIG(MD)) u_sub (
                .a    (w),
                .b    (mult[k]),
                .sub  (1'b1),
                .y    (diff[k]),
                .cout (borrow[k])
            );
        end
    endgenerate

    // largest multiple whose difference does not borrow
    always_comb begin
        qdig = '0;
        rem  = w;
        for (int k = 1; k <= 9; k++) begin
            if (!borrow[k]) begin
                qdig = 4'(k);
                rem  = diff[k];
            end
        end
    end
endmodule

// File: rtl/dec_restoring_div.sv
module dec_restoring_div
    import dd_div_pkg::*;
#(
    parameter int DIGITS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [DIGITS*4-1:0]       dividend,
    input  logic [DIGITS*4-1:0]       divisor,
    output logic [(DIGITS+1)*4-1:0]   quotient,
    output logic [(DIGITS+2)*4-1:0]   quotient_plus1,
    output logic                      sticky,
    output logic                      done
);
    localparam int D4 = DIGITS * 4;
    localparam int MW = (DIGITS + 1) * 4;
    localparam int QW = MW;
    localparam int PW = (DIGITS + 2) * 4;
    localparam int CW = $clog2(DIGITS + 2);

    typedef struct packed {
        dd_state_e          st;
        logic [D4-1:0]      x;
        logic [D4-1:0]      d;
        logic [9:1][MW-1:0] mult;
        logic [D4-1:0]      resid;
        logic               first;
        logic [CW-1:0]      cnt;
        logic [QW-1:0]      quot;
        logic [PW-1:0]      qp1;
        logic               sticky;
        logic               done;
    } dd_regs_t;

    dd_regs_t r_q, r_d;

    logic [9:1][MW-1:0] mult_w;
    logic [MW-1:0]      w_cur, rem_w;
    logic [3:0]         qd;
    logic [3:0]         rem_top_unused;

    assign w_cur = r_q.first ? {4'h0, r_q.x} : {r_q.resid, 4'h0};

    dd_multiples #(.DIGITS(DIGITS)) u_mult (
        .divisor (r_q.d),
        .mult    (mult_w)
    );

    dd_digit_sel #(.DIGITS(DIGITS)) u_sel (
        .w    (w_cur),
        .mult (r_q.mult),
        .qdig (qd),
        .rem  (rem_w)
    );

    // residual stays below the divisor, so the top digit is always zero
    assign rem_top_unused = rem_w[MW-1 -: 4];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_PREP;
                    r_d.x      = dividend;
                    r_d.d      = divisor;
                    r_d.first  = 1'b1;
                    r_d.cnt    = '0;
                    r_d.quot   = '0;
                    r_d.qp1    = PW'(1);
                    r_d.sticky = 1'b0;
                end
            end
            ST_PREP: begin
                r_d.mult = mult_w;
                r_d.st   = ST_ITER;
            end
            ST_ITER: begin
                r_d.first = 1'b0;
                r_d.resid = rem_w[D4-1:0];
                if (!(r_q.first && qd == 4'd0)) begin
                    r_d.quot = {r_q.quot[QW-5:0], qd};
                    r_d.qp1  = (qd == 4'd9) ? {r_q.qp1[PW-5:0], 4'h0}
                                            : {r_q.quot, qd + 4'd1};
                    r_d.cnt  = r_q.cnt + CW'(1);
                    if (r_q.cnt == CW'(DIGITS)) r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.sticky = |r_q.resid;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quotient       = r_q.quot;
    assign quotient_plus1 = r_q.qp1;
    assign sticky         = r_q.sticky;
    assign done           = r_q.done;
endmodule

// File: rtl/dd_div_chk.sv
module dd_div_chk #(
    parameter int DIGITS = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     done,
    input logic [(DIGITS+1)*4-1:0]  quotient,
    input logic [(DIGITS+2)*4-1:0]  quotient_plus1
);
    localparam int QW  = (DIGITS + 1) * 4;
    localparam int LAT = DIGITS + 3;

    logic        busy;
    logic [15:0] cnt;
    logic        quot_ok, qp1_ok;

    // independent tracking of operations from the port side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && (!busy || done)) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 16'd1;
        end
    end

    always_comb begin
        quot_ok = 1'b1;
        qp1_ok  = 1'b1;
        for (int i = 0; i < DIGITS + 1; i++)
            if (quotient[i*4 +: 4] > 4'd9) quot_ok = 1'b0;
        for (int i = 0; i < DIGITS + 2; i++)
            if (quotient_plus1[i*4 +: 4] > 4'd9) qp1_ok = 1'b0;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == 16'(LAT) || cnt == 16'(LAT + 1)));

    p_leading_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quotient[QW-1 -: 4] != 4'd0));

    p_qp1_lsd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quotient_plus1[3:0] ==
                  ((quotient[3:0] == 4'd9) ? 4'd0 : quotient[3:0] + 4'd1)));

    p_digits_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quot_ok && qp1_ok));
endmodule

bind dec_restoring_div dd_div_chk #(.DIGITS(DIGITS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .done           (done),
    .quotient       (quotient),
    .quotient_plus1 (quotient_plus1)
);

// File: tb/dec_restoring_div_tb.sv
module dec_restoring_div_tb;
    localparam int DIGITS = 6;
    localparam int D4 = DIGITS * 4;
    localparam int QW = (DIGITS + 1) * 4;
    localparam int PW = (DIGITS + 2) * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [D4-1:0] dividend = '0;
    logic [D4-1:0] divisor = '0;
    logic [QW-1:0] quotient;
    logic [PW-1:0] quotient_plus1;
    logic          sticky;
    logic          done;

    always #10 clk = ~clk;   // 50 MHz

    dec_restoring_div #(.DIGITS(DIGITS)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .dividend       (dividend),
        .divisor        (divisor),
        .quotient       (quotient),
        .quotient_plus1 (quotient_plus1),
        .sticky         (sticky),
        .done           (done)
    );

    typedef struct {
        logic [QW-1:0] quot;
        logic [PW-1:0] qp1;
        logic          sticky;
        int            norm;
        longint        acc;
        string         req;
    } exp_t;

    exp_t   exp_q[$];
    int     n_chk = 0;
    int     n_fail = 0;
    int     n_issued = 0;
    int     n_done = 0;
    longint cyc = 0;
    logic   last_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic longint pow10(input int n);
        longint r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [PW-1:0] to_bcd(input longint v);
        logic [PW-1:0] r = '0;
        longint t = v;
        for (int i = 0; i < DIGITS + 2; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // driver: called at a falling edge; pushes the expected result
    task automatic issue(input longint x, input longint d, input string req);
        exp_t e;
        longint num, q;
        logic [PW-1:0] bx, bd, bq;
        e.norm   = (x < d) ? 1 : 0;
        num      = x * pow10(DIGITS + e.norm);
        q        = num / d;
        bq       = to_bcd(q);
        e.quot   = bq[QW-1:0];
        e.qp1    = to_bcd(q + 1);
        e.sticky = ((num - q * d) != 0);
        e.acc    = cyc + 1;
        e.req    = req;
        bx       = to_bcd(x);
        bd       = to_bcd(d);
        dividend = bx[D4-1:0];
        divisor  = bd[D4-1:0];
        start    = 1'b1;
        exp_q.push_back(e);
        n_issued++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic run(input longint x, input longint d, input string req);
        issue(x, d, req);
        wait_done();
        repeat (2) @(negedge clk);
    endtask

    // monitor: compares each completed division with the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (last_done)
                check(!done, "R7", "done high for more than one cycle", 64'(done), 64'd0);
            if (done) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "done without accepted start", 64'd1, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(quotient == e.quot, e.req, "quotient",
                          64'(quotient), 64'(e.quot));
                    check(quotient_plus1 == e.qp1, "R4", "quotient plus one",
                          64'(quotient_plus1), 64'(e.qp1));
                    check(sticky == e.sticky, "R5", "sticky",
                          64'(sticky), 64'(e.sticky));
                    check((cyc - e.acc) == longint'(DIGITS + 3 + e.norm), "R6", "latency",
                          64'(cyc - e.acc), 64'(DIGITS + 3 + e.norm));
                end
            end
        end
        last_done = done;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        check(quotient == '0, "R1", "reset quotient", 64'(quotient), 64'd0);
        check(quotient_plus1 == '0, "R1", "reset quotient plus one", 64'(quotient_plus1), 64'd0);
        check(sticky == 1'b0, "R1", "reset sticky", 64'(sticky), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(500000, 250000, "R2");     // exact 2, no remainder
        run(100000, 300000, "R3");     // leading zero dropped
        run(999999, 999999, "R2");     // exactly one
        run(100000, 999999, "R3");     // remainder of one
        run(999999, 100000, "R2");     // largest quotient range
        run(987654, 123457, "R10");    // divisor digits above four
        run(200000, 300000, "R3");     // repeating sixes
        run(555555, 999995, "R10");

        // back-to-back: next start given in the done cycle (R9)
        issue(111111, 777777, "R3");
        wait_done();
        issue(864209, 135797, "R9");
        wait_done();
        issue(123456, 654321, "R9");
        wait_done();
        repeat (2) @(negedge clk);

        // start while busy must be ignored (R8)
        issue(700000, 350000, "R8");
        repeat (2) @(negedge clk);
        dividend = 24'h999999;
        divisor  = 24'h100000;
        start    = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (DIGITS + 8) @(negedge clk);

        // sweep of mixed operands
        for (int i = 0; i < 16; i++) begin
            longint x, d;
            x = 100000 + (longint'(i) * 73129 + 11) % 900000;
            d = 100000 + (longint'(i) * 45677 + 5003) % 900000;
            if (x < d) run(x, d, "R3");
            else       run(x, d, "R2");
        end

        repeat (4) @(negedge clk);
        check(n_done == n_issued, "R8", "completion count", 64'(n_done), 64'(n_issued));
        check(exp_q.size() == 0, "R8", "pending results", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule